// File: doc/BRIEF.md
# Sign-Extending Indexed Load-With-Update Unit

This block is the execute and writeback slice for one kind of load. It reads a signed 16-bit value from memory, widens it to a 32-bit register value and, when allowed, writes the computed address back into the base register. An operation arrives with two operand values and the register numbers of the base and the target. The unit forms the effective address from the base and index operands. A base register number of zero stands for a literal zero, not for the contents of register zero. The unit sends one halfword read to a simple memory port, waits for the response and then issues its register-file writes.

Two conditions can stop an operation. The first is a misalignment fault, raised when strict alignment is enabled and the effective address is odd. The second is a data-storage fault, which the memory port reports together with its response. On either fault the unit drops all register writes and reports the faulting address instead. No arithmetic flags are produced. The unit handles one operation at a time and accepts the next only after the previous one has fully finished.

Top module: `ldupd_unit`

## Requirements
- R1: The effective address is the index operand alone when the base register number is 0. Otherwise it is the base operand plus the index operand, with the sum wrapping modulo 2^32. It appears on `memReqAddr`.
- R2: Each non-misaligned operation raises `memReqValid` once. The request and its address stay unchanged until a cycle in which `memReqReady` is high.
- R3: The response is big-endian. `memRspData[15:8]` is the byte at the effective address and `memRspData[7:0]` is the byte at the next address. The target write data is this halfword in bits 15:0, with bit 15 copied into bits 31:16.
- R4: A non-faulting operation raises `tgtWrEn` for exactly one cycle, with `tgtWrIdx` equal to the target register number.
- R5: `baseWrEn` is high only when the base number is nonzero, the base number differs from the target number, and no fault occurred. `baseWrIdx` is then the base number and `baseWrData` is the effective address.
- R6: When `strictAlign` is 1 at issue and bit 0 of the effective address is 1, no memory request is made and no register is written. `faultValid` pulses for one cycle with `faultAlign`=1 and `faultAddr` equal to the effective address.
- R7: A response with `memRspFault`=1 cancels both register writes. `faultValid` then pulses for one cycle with `faultAlign`=0 and `faultAddr` equal to the effective address.
- R8: `issueReady` is high only while the unit is idle. It stays low from acceptance until the cycle after the writeback or fault pulse.
- R9: With `strictAlign`=0, an odd effective address is loaded and written back exactly as an even one.
- R10: When the base update is permitted, it occurs in the same cycle as the target write, on its own write port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| strictAlign | input | 1 | Fault on odd effective addresses; sampled at issue |
| issueValid | input | 1 | Operation offered |
| issueReady | output | 1 | Unit idle, operation accepted when valid |
| issueBaseIdx | input | IDX_W | Base register number (0 = literal zero) |
| issueTgtIdx | input | IDX_W | Target register number |
| issueBaseVal | input | XLEN | Base register contents |
| issueIdxVal | input | XLEN | Index register contents |
| memReqValid | output | 1 | Halfword read request |
| memReqReady | input | 1 | Memory accepts request |
| memReqAddr | output | XLEN | Byte address of the halfword |
| memRspValid | input | 1 | Read response present |
| memRspData | input | HALF_W | Halfword, byte at address in the high half |
| memRspFault | input | 1 | Data-storage fault on this access |
| tgtWrEn | output | 1 | Target register write |
| tgtWrIdx | output | IDX_W | Target register number |
| tgtWrData | output | XLEN | Sign-extended halfword |
| baseWrEn | output | 1 | Base register update |
| baseWrIdx | output | IDX_W | Base register number |
| baseWrData | output | XLEN | Effective address |
| faultValid | output | 1 | Fault report pulse |
| faultAlign | output | 1 | 1 = misalignment, 0 = data-storage fault |
| faultAddr | output | XLEN | Faulting effective address |

## Verification
The bench builds the unit with `IDX_W`=3, which gives eight register numbers. With so few, every base and target pairing can be swept, including base zero, base equal to target and both zero, under each of four access kinds: even, odd with strict alignment off, odd with strict alignment on, and data-storage fault. The operands are picked so that nonzero bases overflow the 32-bit sum, which exercises the wrap in the same sweep. A second sweep walks all 256 high-byte values of the halfword to cover sign extension and byte order. Request stalls of zero to two cycles vary across the runs.

// File: rtl/ldupd_pkg.sv
package ldupd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_DONE,
    ST_AFLT
  } ldState_t;

  typedef struct packed {
    logic latchOp;
    logic latchRsp;
  } ctrlStrobes_t;

endpackage

// File: rtl/ldupd_dpath.sv
module ldupd_dpath
  import ldupd_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int HALF_W = 16,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [IDX_W-1:0]  issueBaseIdx,
  input  logic [IDX_W-1:0]  issueTgtIdx,
  input  logic [XLEN-1:0]   issueBaseVal,
  input  logic [XLEN-1:0]   issueIdxVal,
  input  logic [HALF_W-1:0] memRspData,
  output logic [XLEN-1:0]   ea,
  output logic              eaOdd,
  output logic [XLEN-1:0]   result,
  output logic [IDX_W-1:0]  baseIdx,
  output logic [IDX_W-1:0]  tgtIdx,
  output logic              updateOk
);

  localparam int EXT_W = XLEN - HALF_W;

  logic [XLEN-1:0]   eaNext;
  logic [XLEN-1:0]   eaQ;
  logic [IDX_W-1:0]  baseIdxQ;
  logic [IDX_W-1:0]  tgtIdxQ;
  logic [HALF_W-1:0] halfQ;

  // Address adder sits in front of the operand register.
  always_comb begin
    if (issueBaseIdx == '0) eaNext = issueIdxVal;
    else                    eaNext = issueBaseVal + issueIdxVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eaQ      <= '0;
      baseIdxQ <= '0;
      tgtIdxQ  <= '0;
      halfQ    <= '0;
    end else begin
      if (strb.latchOp) begin
        eaQ      <= eaNext;
        baseIdxQ <= issueBaseIdx;
        tgtIdxQ  <= issueTgtIdx;
      end
      if (strb.latchRsp) halfQ <= memRspData;
    end
  end

  assign ea       = eaQ;
  assign eaOdd    = eaQ[0];
  assign baseIdx  = baseIdxQ;
  assign tgtIdx   = tgtIdxQ;
  assign updateOk = (baseIdxQ != '0) && (baseIdxQ != tgtIdxQ);
  assign result   = {{EXT_W{halfQ[HALF_W-1]}}, halfQ};

  AST_EA_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latchOp |=> $stable(eaQ)); // R2

endmodule

// File: rtl/ldupd_ctrl.sv
module ldupd_ctrl
  import ldupd_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         issueValid,
  input  logic         strictAlign,
  input  logic         memReqReady,
  input  logic         memRspValid,
  input  logic         memRspFault,
  input  logic         eaOdd,
  input  logic         updateOk,
  output logic         issueReady,
  output logic         memReqValid,
  output logic         tgtWrEn,
  output logic         baseWrEn,
  output logic         faultValid,
  output logic         faultAlign,
  output ctrlStrobes_t strb
);

  ldState_t state, stateNext;
  logic     strictQ;
  logic     dsFaultQ;
  logic     misaligned;

  assign misaligned = strictQ && eaOdd;

  always_comb begin
    stateNext     = state;
    issueReady    = 1'b0;
    memReqValid   = 1'b0;
    tgtWrEn       = 1'b0;
    baseWrEn      = 1'b0;
    faultValid    = 1'b0;
    faultAlign    = 1'b0;
    strb.latchOp  = 1'b0;
    strb.latchRsp = 1'b0;
    unique case (state)
      ST_IDLE: begin
        issueReady   = 1'b1;
        strb.latchOp = issueValid;
        if (issueValid) stateNext = ST_REQ;
      end
      ST_REQ: begin
        if (misaligned) begin
          stateNext = ST_AFLT;
        end else begin
          memReqValid = 1'b1;
          if (memReqReady) stateNext = ST_WAIT;
        end
      end
      ST_WAIT: begin
        strb.latchRsp = memRspValid;
        if (memRspValid) stateNext = ST_DONE;
      end
      ST_DONE: begin
        faultValid = dsFaultQ;
        tgtWrEn    = !dsFaultQ;
        baseWrEn   = !dsFaultQ && updateOk;
        stateNext  = ST_IDLE;
      end
      ST_AFLT: begin
        faultValid = 1'b1;
        faultAlign = 1'b1;
        stateNext  = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      strictQ  <= 1'b0;
      dsFaultQ <= 1'b0;
    end else begin
      state <= stateNext;
      if (strb.latchOp)  strictQ  <= strictAlign;
      if (strb.latchRsp) dsFaultQ <= memRspFault;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid); // R2
  AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> !tgtWrEn && !baseWrEn); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    issueReady |-> !(tgtWrEn || baseWrEn || faultValid || memReqValid)); // R8
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (tgtWrEn || faultValid) |=> issueReady); // R8

endmodule

// File: rtl/ldupd_unit.sv
module ldupd_unit
  import ldupd_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int HALF_W = 16,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strictAlign,
  input  logic              issueValid,
  output logic              issueReady,
  input  logic [IDX_W-1:0]  issueBaseIdx,
  input  logic [IDX_W-1:0]  issueTgtIdx,
  input  logic [XLEN-1:0]   issueBaseVal,
  input  logic [XLEN-1:0]   issueIdxVal,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [XLEN-1:0]   memReqAddr,
  input  logic              memRspValid,
  input  logic [HALF_W-1:0] memRspData,
  input  logic              memRspFault,
  output logic              tgtWrEn,
  output logic [IDX_W-1:0]  tgtWrIdx,
  output logic [XLEN-1:0]   tgtWrData,
  output logic              baseWrEn,
  output logic [IDX_W-1:0]  baseWrIdx,
  output logic [XLEN-1:0]   baseWrData,
  output logic              faultValid,
  output logic              faultAlign,
  output logic [XLEN-1:0]   faultAddr
);

  ctrlStrobes_t    strb;
  logic [XLEN-1:0] ea;
  logic            eaOdd;
  logic            updateOk;

  ldupd_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .issueValid  (issueValid),
    .strictAlign (strictAlign),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .memRspFault (memRspFault),
    .eaOdd       (eaOdd),
    .updateOk    (updateOk),
    .issueReady  (issueReady),
    .memReqValid (memReqValid),
    .tgtWrEn     (tgtWrEn),
    .baseWrEn    (baseWrEn),
    .faultValid  (faultValid),
    .faultAlign  (faultAlign),
    .strb        (strb)
  );

  ldupd_dpath #(.XLEN(XLEN), .HALF_W(HALF_W), .IDX_W(IDX_W)) dpath_i (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .issueBaseIdx (issueBaseIdx),
    .issueTgtIdx  (issueTgtIdx),
    .issueBaseVal (issueBaseVal),
    .issueIdxVal  (issueIdxVal),
    .memRspData   (memRspData),
    .ea           (ea),
    .eaOdd        (eaOdd),
    .result       (tgtWrData),
    .baseIdx      (baseWrIdx),
    .tgtIdx       (tgtWrIdx),
    .updateOk     (updateOk)
  );

  assign memReqAddr = ea;
  assign baseWrData = ea;
  assign faultAddr  = ea;

  AST_BASE_WITH_TGT: assert property (@(posedge clk) disable iff (!rstN)
    baseWrEn |-> tgtWrEn); // R10
  AST_BASE_IDX_RULE: assert property (@(posedge clk) disable iff (!rstN)
    baseWrEn |-> (baseWrIdx != '0) && (baseWrIdx != tgtWrIdx)); // R5
  AST_ALIGN_ODD: assert property (@(posedge clk) disable iff (!rstN)
    faultValid && faultAlign |-> faultAddr[0]); // R6

endmodule

// File: tb/ldupd_unit_tb.sv
module ldupd_unit_tb_top;

  localparam int XLEN   = 32;
  localparam int HALF_W = 16;
  localparam int IDX_W  = 3;
  localparam int NREG   = 1 << IDX_W;

  logic              clk = 1'b0;
  logic              rstN;
  logic              strictAlign;
  logic              issueValid;
  logic              issueReady;
  logic [IDX_W-1:0]  issueBaseIdx;
  logic [IDX_W-1:0]  issueTgtIdx;
  logic [XLEN-1:0]   issueBaseVal;
  logic [XLEN-1:0]   issueIdxVal;
  logic              memReqValid;
  logic              memReqReady;
  logic [XLEN-1:0]   memReqAddr;
  logic              memRspValid;
  logic [HALF_W-1:0] memRspData;
  logic              memRspFault;
  logic              tgtWrEn;
  logic [IDX_W-1:0]  tgtWrIdx;
  logic [XLEN-1:0]   tgtWrData;
  logic              baseWrEn;
  logic [IDX_W-1:0]  baseWrIdx;
  logic [XLEN-1:0]   baseWrData;
  logic              faultValid;
  logic              faultAlign;
  logic [XLEN-1:0]   faultAddr;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  ldupd_unit #(.XLEN(XLEN), .HALF_W(HALF_W), .IDX_W(IDX_W)) dut_i (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic runOp(input int ra, input int rt, input logic [31:0] bv, input logic [31:0] xv,
                       input bit strict, input logic [15:0] half, input bit ds, input int stallIn);
    logic [31:0] expEa, expRes;
    bit expAlign, expUpd, reqSeen, rspPending, done, leak;
    int stall;
    stall  = stallIn;
    expEa  = (ra == 0) ? xv : bv + xv;
    expRes = {{16{half[15]}}, half};
    expAlign = strict && expEa[0];
    expUpd   = (ra != 0) && (ra != rt) && !expAlign && !ds;
    reqSeen = 0; rspPending = 0; done = 0; leak = 0;

    @(negedge clk);
    chk(issueReady == 1'b1, "R8 idle before issue", {31'b0, issueReady}, 32'd1);
    issueValid   = 1'b1;
    issueBaseIdx = IDX_W'(ra);
    issueTgtIdx  = IDX_W'(rt);
    issueBaseVal = bv;
    issueIdxVal  = xv;
    strictAlign  = strict;
    @(negedge clk);
    issueValid  = 1'b0;
    strictAlign = ~strict;   // must have no effect once issued
    for (int c = 0; c < 40 && !done; c++) begin
      memRspValid = 1'b0; memRspFault = 1'b0; memRspData = '0; memReqReady = 1'b0;
      if (rspPending) begin
        memRspValid = 1'b1; memRspData = half; memRspFault = ds; rspPending = 0;
      end
      if (issueReady) leak = 1;
      if (tgtWrEn || faultValid) begin
        done = 1;
      end else if (memReqValid) begin
        reqSeen = 1;
        chk(memReqAddr == expEa, "R1/R2 request address", memReqAddr, expEa);
        if (stall > 0) stall--;
        else begin memReqReady = 1'b1; rspPending = 1; end
      end
      if (!done) @(negedge clk);
    end
    chk(done, "R8 operation completes", {31'b0, done}, 32'd1);
    chk(!leak, "R8 not ready while busy", {31'b0, leak}, 32'd0);
    chk(reqSeen == !expAlign, "R6 request issued only when aligned", {31'b0, reqSeen}, {31'b0, !expAlign});
    if (expAlign) begin
      chk(faultValid && faultAlign, "R6 misalign fault", {30'b0, faultValid, faultAlign}, 32'd3);
      chk(faultAddr == expEa, "R6 fault address", faultAddr, expEa);
      chk(!tgtWrEn && !baseWrEn, "R6 no writes", {30'b0, tgtWrEn, baseWrEn}, 32'd0);
    end else if (ds) begin
      chk(faultValid && !faultAlign, "R7 storage fault", {30'b0, faultValid, faultAlign}, 32'd2);
      chk(faultAddr == expEa, "R7 fault address", faultAddr, expEa);
      chk(!tgtWrEn && !baseWrEn, "R7 no writes", {30'b0, tgtWrEn, baseWrEn}, 32'd0);
    end else begin
      chk(tgtWrEn && !faultValid, "R4 target write", {30'b0, tgtWrEn, faultValid}, 32'd2);
      chk(tgtWrIdx == IDX_W'(rt), "R4 target index", 32'(tgtWrIdx), 32'(rt));
      chk(tgtWrData == expRes, expEa[0] ? "R9 odd load result" : "R3 sign-extended result",
          tgtWrData, expRes);
      chk(baseWrEn == expUpd, "R5 base update enable", {31'b0, baseWrEn}, {31'b0, expUpd});
      if (expUpd) begin
        chk(baseWrIdx == IDX_W'(ra) && baseWrData == expEa && tgtWrEn,
            "R10 base update with target", baseWrData, expEa);
      end
    end
    strictAlign = 1'b0;
  endtask

  initial begin
    rstN = 1'b0; strictAlign = 1'b0; issueValid = 1'b0;
    issueBaseIdx = '0; issueTgtIdx = '0; issueBaseVal = '0; issueIdxVal = '0;
    memReqReady = 1'b0; memRspValid = 1'b0; memRspData = '0; memRspFault = 1'b0;
    repeat (3) @(negedge clk);
    chk(issueReady && !memReqValid && !tgtWrEn && !baseWrEn && !faultValid, "R8 reset state",
        {27'b0, issueReady, memReqValid, tgtWrEn, baseWrEn, faultValid}, 32'h10);
    rstN = 1'b1;

    // Every base/target pairing under four access kinds; nonzero bases wrap the sum (R1).
    for (int ra = 0; ra < NREG; ra++) begin
      for (int rt = 0; rt < NREG; rt++) begin
        for (int kind = 0; kind < 4; kind++) begin
          logic [31:0] bv, xv;
          logic [15:0] h;
          bv = 32'hFFFF_FF00 + 32'(ra << 4);
          xv = 32'h0000_0200 + 32'(rt << 2) + ((kind == 1 || kind == 2) ? 32'd1 : 32'd0);
          h  = 16'h8000 ^ 16'((ra * NREG + rt) * 16'h0123 + kind);
          runOp(ra, rt, bv, xv, (kind == 2 || kind == 3), h, (kind == 3), (ra + rt + kind) % 3);
        end
      end
    end

    // Sign and byte-order sweep over the high byte (R3).
    for (int hi = 0; hi < 256; hi++) begin
      logic [7:0] b;
      b = 8'(hi);
      runOp(1, 2, 32'h0000_0100, 32'h0000_0020, 1'b1, {b, ~b}, 1'b0, hi % 2);
    end

    @(negedge clk);
    chk(issueReady, "R8 idle at end", {31'b0, issueReady}, 32'd1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule